// File: doc/BRIEF.md
# Dual-Width Accumulator ALU

This block is the accumulator datapath of a small 16-bit signal processor. On each cycle where the execute strobe is high, it decodes an operation class and a source index from the opcode. It then applies subtract, compare, add, AND, OR or XOR between the 32-bit accumulator and an operand. It also updates a 16-bit status word that holds zero, negative, overflow and carry-style flags.

Ordinary sources are one half-word wide and act on the upper half of the accumulator. When the source index names the product register, the same operation instead runs over the full accumulator width using the full-width product value. The accumulator and the status word are registered, so a result appears one clock after the strobe. Fetching instructions, decoding the register file and forming the product all happen outside this block.

Top module: `acc_alu`

## Requirements
- R1: A synchronous active-high reset clears the accumulator to 0 and the status word to 0.
- R2: When the strobe is low, or when the opcode class field (opcode[7:4]) is not one of 1, 3, 4, 5, 6 or 7, neither the accumulator nor the status word changes.
- R3: Half-width form of subtract (class 1) and add (class 4), used when the source index (opcode[3:0]) is not 11: the upper half becomes the upper half minus or plus the source value, modulo 2^16. The lower half keeps its value.
- R4: Full-width form of subtract and add, used when the source index is 11: the whole accumulator becomes the accumulator minus or plus the product value, modulo 2^32.
- R5: Compare (class 3) forms the same difference as subtract, in either width, and updates the flags from it. It leaves the accumulator unchanged.
- R6: Status layout is N at bit 15, V at bit 14, Z at bit 13 and L at bit 12; all other bits stay 0. An arithmetic op (subtract, compare, add) clears L, V, Z and N. It then sets Z if the result is zero. Otherwise it sets N to the result's top bit: bit 15 of the 16-bit result in half-width form, bit 31 in full-width form.
- R7: Half-width AND (class 5) ANDs the accumulator with the source value placed in the upper half and zeros below it, so the lower half becomes 0.
- R8: Half-width OR (class 6) and XOR (class 7) combine the source value into the upper half only and keep the lower half unchanged.
- R9: Full-width AND, OR and XOR (source index 11) combine the whole accumulator with the product value.
- R10: Logic ops set Z when the new accumulator is zero and set N to its bit 31; they do not change V or L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec | input | 1 | Execute strobe, one operation per high cycle |
| opcode | input | 8 | Class field in [7:4], source index in [3:0] |
| src_val | input | 16 | Half-width source operand |
| prod_val | input | 32 | Full-width product operand |
| acc | output | 32 | Accumulator register |
| status | output | 16 | Status word (N15, V14, Z13, L12) |

## Verification
The bench builds the block with its defaults: a 16-bit half-word, a 4-bit class field and a 4-bit source field, with the product at source index 11. These values put both wrap points within reach of short directed sequences, 0xFFFF in the upper half and 0xFFFFFFFF over the full width. It also makes it easy to show that a low-half pattern survives or is cleared, depending on the logic op. Source indexes 10 and 12, on either side of the product index, confirm that only index 11 selects the full-width form.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_SUB,
    OP_CMP,
    OP_ADD,
    OP_AND,
    OP_OR,
    OP_XOR
  } alu_op_e;

  localparam int ST_W  = 16;
  localparam int BIT_N = 15;
  localparam int BIT_V = 14;
  localparam int BIT_Z = 13;
  localparam int BIT_L = 12;

  typedef struct packed {
    alu_op_e op;
    logic    wide;
    logic    arith;
    logic    writes;
  } dec_t;

endpackage

// File: rtl/acc_alu_dec.sv
module acc_alu_dec
  import acc_alu_pkg::*;
#(
  parameter int CLS_W    = 4,
  parameter int SRC_W    = 4,
  parameter int PROD_IDX = 11,
  localparam int OPC_W   = CLS_W + SRC_W
) (
  input  logic [OPC_W-1:0] opcode_i,
  output dec_t             dec_o
);

  logic [CLS_W-1:0] cls;
  logic [SRC_W-1:0] idx;

  assign cls = opcode_i[OPC_W-1:SRC_W];
  assign idx = opcode_i[SRC_W-1:0];

  always_comb begin
    dec_o.op = OP_NONE;
    unique case (cls)
      CLS_W'(1): dec_o.op = OP_SUB;
      CLS_W'(3): dec_o.op = OP_CMP;
      CLS_W'(4): dec_o.op = OP_ADD;
      CLS_W'(5): dec_o.op = OP_AND;
      CLS_W'(6): dec_o.op = OP_OR;
      CLS_W'(7): dec_o.op = OP_XOR;
      default:   dec_o.op = OP_NONE;
    endcase
    dec_o.wide   = (idx == SRC_W'(PROD_IDX));
    dec_o.arith  = (dec_o.op == OP_SUB) || (dec_o.op == OP_CMP) ||
                   (dec_o.op == OP_ADD);
    dec_o.writes = (dec_o.op != OP_NONE) && (dec_o.op != OP_CMP);
  end

endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int HALF_W = 16,
  localparam int ACC_W = 2 * HALF_W
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [HALF_W-1:0] src_i,
  input  logic [ACC_W-1:0]  prod_i,
  input  logic              wide_i,
  input  logic              sub_i,
  output logic [ACC_W-1:0]  res_o,
  output logic              zero_o,
  output logic              neg_o
);

  logic [ACC_W-1:0]  full_res;
  logic [HALF_W-1:0] half_res;

  assign full_res = sub_i ? (acc_i - prod_i) : (acc_i + prod_i);
  assign half_res = sub_i ? (acc_i[ACC_W-1:HALF_W] - src_i)
                          : (acc_i[ACC_W-1:HALF_W] + src_i);

  always_comb begin
    if (wide_i) begin
      res_o  = full_res;
      zero_o = (full_res == '0);
      neg_o  = full_res[ACC_W-1];
    end else begin
      res_o  = {half_res, acc_i[HALF_W-1:0]};
      zero_o = (half_res == '0);
      neg_o  = half_res[HALF_W-1];
    end
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int HALF_W = 16,
  localparam int ACC_W = 2 * HALF_W
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [HALF_W-1:0] src_i,
  input  logic [ACC_W-1:0]  prod_i,
  input  logic              wide_i,
  input  alu_op_e           op_i,
  output logic [ACC_W-1:0]  res_o,
  output logic              zero_o,
  output logic              neg_o
);

  logic [ACC_W-1:0] operand;

  assign operand = wide_i ? prod_i : {src_i, {HALF_W{1'b0}}};

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = acc_i & operand;
      OP_OR:   res_o = acc_i | operand;
      OP_XOR:  res_o = acc_i ^ operand;
      default: res_o = acc_i;
    endcase
    zero_o = (res_o == '0);
    neg_o  = res_o[ACC_W-1];
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int HALF_W   = 16,
  parameter int CLS_W    = 4,
  parameter int SRC_W    = 4,
  parameter int PROD_IDX = 11,
  localparam int ACC_W   = 2 * HALF_W,
  localparam int OPC_W   = CLS_W + SRC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [HALF_W-1:0] src_val,
  input  logic [ACC_W-1:0]  prod_val,
  output logic [ACC_W-1:0]  acc,
  output logic [ST_W-1:0]   status
);

  dec_t             dec;
  logic [ACC_W-1:0] acc_q;
  logic [ST_W-1:0]  status_q;
  logic [ACC_W-1:0] ar_res, lg_res;
  logic             ar_z, ar_n, lg_z, lg_n;
  logic [ACC_W-1:0] acc_d;
  logic [ST_W-1:0]  status_d;

  acc_alu_dec #(
    .CLS_W(CLS_W), .SRC_W(SRC_W), .PROD_IDX(PROD_IDX)
  ) u_dec (
    .opcode_i(opcode),
    .dec_o   (dec)
  );

  acc_alu_arith #(.HALF_W(HALF_W)) u_arith (
    .acc_i (acc_q),
    .src_i (src_val),
    .prod_i(prod_val),
    .wide_i(dec.wide),
    .sub_i (dec.op != OP_ADD),
    .res_o (ar_res),
    .zero_o(ar_z),
    .neg_o (ar_n)
  );

  acc_alu_logic #(.HALF_W(HALF_W)) u_logic (
    .acc_i (acc_q),
    .src_i (src_val),
    .prod_i(prod_val),
    .wide_i(dec.wide),
    .op_i  (dec.op),
    .res_o (lg_res),
    .zero_o(lg_z),
    .neg_o (lg_n)
  );

  always_comb begin
    acc_d    = acc_q;
    status_d = status_q;
    if (exec && dec.op != OP_NONE) begin
      if (dec.arith) begin
        status_d[BIT_L] = 1'b0;
        status_d[BIT_V] = 1'b0;
        status_d[BIT_Z] = ar_z;
        status_d[BIT_N] = ar_n & ~ar_z;
        if (dec.writes) acc_d = ar_res;
      end else begin
        status_d[BIT_Z] = lg_z;
        status_d[BIT_N] = lg_n;
        acc_d           = lg_res;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      status_q <= '0;
    end else begin
      acc_q    <= acc_d;
      status_q <= status_d;
    end
  end

  assign acc    = acc_q;
  assign status = status_q;

  // R2: idle or unused class leaves all state alone
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!exec || dec.op == OP_NONE) |=> ($stable(acc_q) && $stable(status_q)));

  // R5: compare never writes the accumulator
  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (exec && dec.op == OP_CMP) |=> $stable(acc_q));

  // R3 / R8: half-width add, subtract, OR, XOR keep the low half
  assert_half_low_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (exec && !dec.wide && (dec.op == OP_SUB || dec.op == OP_ADD ||
      dec.op == OP_OR || dec.op == OP_XOR)) |=> $stable(acc_q[HALF_W-1:0]));

  // R7: half-width AND clears the low half
  assert_half_and_low_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (exec && !dec.wide && dec.op == OP_AND) |=> (acc_q[HALF_W-1:0] == '0));

  // R6: arithmetic leaves V and L cleared, Z and N never both set
  assert_arith_vl_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (exec && dec.arith) |=> (!status_q[BIT_V] && !status_q[BIT_L] &&
      !(status_q[BIT_Z] && status_q[BIT_N])));

  // R10: logic ops keep V and L
  assert_logic_vl_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (exec && dec.op != OP_NONE && !dec.arith) |=>
      ($stable(status_q[BIT_V]) && $stable(status_q[BIT_L])));

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        exec;
  logic [7:0]  opcode;
  logic [15:0] src_val;
  logic [31:0] prod_val;
  logic [31:0] acc;
  logic [15:0] status;

  int checks = 0;
  int errors = 0;

  localparam logic [15:0] N = 16'h8000;
  localparam logic [15:0] Z = 16'h2000;

  always #5 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst(rst), .exec(exec), .opcode(opcode),
    .src_val(src_val), .prod_val(prod_val), .acc(acc), .status(status)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] opc, input logic [15:0] s,
                        input logic [31:0] p, input logic strobe);
    @(negedge clk);
    opcode = opc; src_val = s; prod_val = p; exec = strobe;
    @(negedge clk);
    exec = 1'b0;
  endtask

  task automatic expect_state(input string req, input logic [31:0] ea,
                              input logic [15:0] es);
    check(req, acc, ea, "acc");
    check(req, {16'h0, status}, {16'h0, es}, "status");
  endtask

  task automatic t_reset;
    rst = 1'b1; exec = 1'b0; opcode = '0; src_val = '0; prod_val = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_state("R1", 32'h0, 16'h0);
  endtask

  task automatic t_full_arith;
    run_op(8'h4B, 16'h0, 32'h12345678, 1'b1);
    expect_state("R4", 32'h12345678, 16'h0);
    run_op(8'h1B, 16'h0, 32'h12345679, 1'b1);
    expect_state("R4", 32'hFFFFFFFF, N);
    run_op(8'h4B, 16'h0, 32'h00000001, 1'b1);
    expect_state("R4", 32'h0, Z);
    run_op(8'h4B, 16'h0, 32'hABCD1234, 1'b1);
    expect_state("R6", 32'hABCD1234, N);
  endtask

  task automatic t_half_arith;
    run_op(8'h4A, 16'h0001, 32'hFFFFFFFF, 1'b1);
    expect_state("R3", 32'hABCE1234, N);
    run_op(8'h1C, 16'h2BCE, 32'h0, 1'b1);
    expect_state("R3", 32'h80001234, N);
    run_op(8'h10, 16'h8000, 32'h0, 1'b1);
    expect_state("R6", 32'h00001234, Z);
    run_op(8'h41, 16'hFFFF, 32'h0, 1'b1);
    expect_state("R3", 32'hFFFF1234, N);
    run_op(8'h42, 16'h0003, 32'h0, 1'b1);
    expect_state("R3", 32'h00021234, 16'h0);
  endtask

  task automatic t_compare;
    run_op(8'h30, 16'h0002, 32'h0, 1'b1);
    expect_state("R5", 32'h00021234, Z);
    run_op(8'h30, 16'h0003, 32'h0, 1'b1);
    expect_state("R5", 32'h00021234, N);
    run_op(8'h3B, 16'h0, 32'h00021233, 1'b1);
    expect_state("R5", 32'h00021234, 16'h0);
  endtask

  task automatic t_idle;
    run_op(8'h4B, 16'h0, 32'h11111111, 1'b0);
    expect_state("R2", 32'h00021234, 16'h0);
    run_op(8'h2B, 16'h0, 32'h11111111, 1'b1);
    expect_state("R2", 32'h00021234, 16'h0);
    run_op(8'h8B, 16'h0, 32'h11111111, 1'b1);
    expect_state("R2", 32'h00021234, 16'h0);
  endtask

  task automatic t_half_logic;
    run_op(8'h60, 16'hF000, 32'h0, 1'b1);
    expect_state("R8", 32'hF0021234, N);
    run_op(8'h70, 16'hF002, 32'h0, 1'b1);
    expect_state("R8", 32'h00001234, 16'h0);
    run_op(8'h61, 16'h0F0F, 32'h0, 1'b1);
    expect_state("R8", 32'h0F0F1234, 16'h0);
    run_op(8'h51, 16'hFF00, 32'h0, 1'b1);
    expect_state("R7", 32'h0F000000, 16'h0);
    run_op(8'h52, 16'h00FF, 32'h0, 1'b1);
    expect_state("R10", 32'h0, Z);
  endtask

  task automatic t_full_logic;
    run_op(8'h6B, 16'hFFFF, 32'h8000A5A5, 1'b1);
    expect_state("R9", 32'h8000A5A5, N);
    run_op(8'h7B, 16'h0, 32'h0000FFFF, 1'b1);
    expect_state("R9", 32'h80005A5A, N);
    run_op(8'h5B, 16'h0, 32'h00FF00FF, 1'b1);
    expect_state("R9", 32'h0000005A, 16'h0);
    run_op(8'h7B, 16'h0, 32'h0000005A, 1'b1);
    expect_state("R10", 32'h0, Z);
  endtask

  initial begin
    t_reset();
    t_full_arith();
    t_half_arith();
    t_compare();
    t_idle();
    t_half_logic();
    t_full_logic();
    run_op(8'h4B, 16'h0, 32'h55555555, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    expect_state("R1", 32'h0, 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule